// File: doc/BRIEF.md
# Two-Line Character Display Sequencer

This block walks a 16x2 character display through a fixed script of 39 bytes and hands them one at a time to a downstream byte writer. The writer turns each byte into bus traffic. The script has four parts. Six setup commands come first. Sixteen characters for the upper line follow. Next comes one command that moves the cursor to the start of the lower line. Sixteen characters for the lower line finish the script. Each byte travels with a register-select bit: 0 marks a command and 1 marks a character.

The two row strings are captured when the script begins. A host may therefore change its text while the script runs without mixing old and new characters on the screen. The byte path is a valid/ready stream. While `out_valid` is high, `out_byte` and `out_rs` stay fixed until a cycle in which `out_ready` is also high. That cycle counts as one transfer, and the next entry appears on the following cycle. The writer can hold `out_ready` low for as long as it needs, and nothing is lost or skipped. After the last transfer the block raises `finished` and waits for a new start pulse.

Top module: `lcd_line_sequencer`

## Requirements
- R1: Reset is synchronous and active low. During reset and on the cycle after it, `out_valid` and `finished` are 0.
- R2: A `start` pulse while no script is running (idle or finished) raises `out_valid` on the next cycle, presenting entry 0.
- R3: Entries 0 to 5 are the commands 0x02, 0x28, 0x0C, 0x06, 0x01, 0x80, in that order, each with `out_rs` = 0.
- R4: Entries 6 to 21 are the 16 bytes of `row_top`, starting with bits [127:120] (leftmost character) and moving down, each with `out_rs` = 1.
- R5: Entry 22 is command 0xC0 with `out_rs` = 0.
- R6: Entries 23 to 38 are the 16 bytes of `row_bottom`, starting with bits [127:120], each with `out_rs` = 1.
- R7: While `out_valid` = 1 and `out_ready` = 0, `out_valid`, `out_byte` and `out_rs` hold their values into the next cycle.
- R8: Each transfer (`out_valid` and `out_ready` both high) advances the script by exactly one entry. A full script is exactly 39 transfers.
- R9: On the cycle after the transfer of entry 38, `out_valid` drops to 0 and `finished` rises to 1. `finished` stays 1 and `out_valid` stays 0 until the next start or reset.
- R10: Both rows are captured on the start cycle. Later changes to `row_top` or `row_bottom` have no effect on the running script.
- R11: A `start` pulse while the script is running is ignored. The current entry and its order are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin the script (ignored while running) |
| row_top | input | 128 | Upper line text, leftmost character in the top byte |
| row_bottom | input | 128 | Lower line text, leftmost character in the top byte |
| out_valid | output | 1 | A byte is offered to the writer |
| out_ready | input | 1 | Writer accepts the offered byte |
| out_byte | output | 8 | Command or character byte |
| out_rs | output | 1 | 0 = command, 1 = character |
| finished | output | 1 | Script complete, waiting for start |

## Verification
The first entry becomes visible one cycle after the clock edge that samples `start`. Each later entry appears one cycle after the edge at which its predecessor was transferred, and `finished` rises one cycle after the transfer of entry 38. The bench keeps a behavioural model that takes the same edges, using the inputs driven half a cycle earlier. It compares all outputs at every falling edge, so each result is checked in exactly the cycle it is due. Ready patterns range from always-high to mostly-low, so stalls fall on every part of the script.

// File: rtl/lcdseq_pkg.sv
package lcdseq_pkg;
  localparam int BYTE_W     = 8;
  localparam int SETUP_CNT  = 6;
  localparam logic [BYTE_W-1:0] LINE2_CMD = 8'hC0;

  typedef enum logic [1:0] {PH_IDLE, PH_RUN, PH_DONE} phase_t;

  function automatic logic [BYTE_W-1:0] setup_cmd(input int k);
    case (k)
      0:       setup_cmd = 8'h02;
      1:       setup_cmd = 8'h28;
      2:       setup_cmd = 8'h0C;
      3:       setup_cmd = 8'h06;
      4:       setup_cmd = 8'h01;
      default: setup_cmd = 8'h80;
    endcase
  endfunction
endpackage

// File: rtl/lcdseq_row_store.sv
module lcdseq_row_store #(
  parameter int ROW_W = 128,
  parameter int LINES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load,
  input  logic [LINES-1:0][ROW_W-1:0] rows_in,
  output logic [LINES-1:0][ROW_W-1:0] rows_q
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n)    rows_q[g] <= '0;
      else if (load) rows_q[g] <= rows_in[g];
    end
  end
endmodule

// File: rtl/lcdseq_index.sv
module lcdseq_index #(
  parameter int COUNT = 39,
  localparam int IW   = $clog2(COUNT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  output logic [IW-1:0] idx,
  output logic          last
);
  always_ff @(posedge clk) begin
    if (!rst_n || clear) idx <= '0;
    else if (step)       idx <= idx + 1'b1;
  end
  assign last = (idx == IW'(COUNT - 1));
endmodule

// File: rtl/lcdseq_entry_sel.sv
module lcdseq_entry_sel
  import lcdseq_pkg::*;
#(
  parameter int CHARS = 16,
  parameter int IW    = 6,
  localparam int ROW_W = CHARS * BYTE_W
) (
  input  logic [IW-1:0]     idx,
  input  logic [ROW_W-1:0]  top_q,
  input  logic [ROW_W-1:0]  bot_q,
  output logic [BYTE_W-1:0] byte_o,
  output logic              rs_o
);
  localparam int TOP_BASE = SETUP_CNT;
  localparam int JUMP_IDX = SETUP_CNT + CHARS;
  localparam int BOT_BASE = JUMP_IDX + 1;

  int k;
  always_comb begin
    k = int'(idx);
    if (k < TOP_BASE) begin
      byte_o = setup_cmd(k);
      rs_o   = 1'b0;
    end else if (k < JUMP_IDX) begin
      byte_o = top_q[(CHARS - 1 - (k - TOP_BASE)) * BYTE_W +: BYTE_W];
      rs_o   = 1'b1;
    end else if (k == JUMP_IDX) begin
      byte_o = LINE2_CMD;
      rs_o   = 1'b0;
    end else begin
      byte_o = bot_q[(CHARS - 1 - (k - BOT_BASE)) * BYTE_W +: BYTE_W];
      rs_o   = 1'b1;
    end
  end
endmodule

// File: rtl/lcd_line_sequencer.sv
module lcd_line_sequencer
  import lcdseq_pkg::*;
#(
  parameter int CHARS = 16,
  localparam int ROW_W    = CHARS * BYTE_W,
  localparam int N_ENTRIES = SETUP_CNT + 2 * CHARS + 1,
  localparam int IW       = $clog2(N_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ROW_W-1:0]  row_top,
  input  logic [ROW_W-1:0]  row_bottom,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_byte,
  output logic              out_rs,
  output logic              finished
);
  phase_t               phase;
  logic                 launch, xfer, at_last;
  logic [IW-1:0]        idx;
  logic [1:0][ROW_W-1:0] rows_q;

  assign launch = start && (phase != PH_RUN);
  assign xfer   = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)                 phase <= PH_IDLE;
    else if (launch)            phase <= PH_RUN;
    else if (xfer && at_last)   phase <= PH_DONE;
  end

  assign out_valid = (phase == PH_RUN);
  assign finished  = (phase == PH_DONE);

  lcdseq_row_store #(.ROW_W(ROW_W), .LINES(2)) u_rows (
    .clk(clk), .rst_n(rst_n), .load(launch),
    .rows_in({row_bottom, row_top}), .rows_q(rows_q)
  );

  lcdseq_index #(.COUNT(N_ENTRIES)) u_idx (
    .clk(clk), .rst_n(rst_n), .clear(launch),
    .step(xfer && !at_last), .idx(idx), .last(at_last)
  );

  lcdseq_entry_sel #(.CHARS(CHARS), .IW(IW)) u_sel (
    .idx(idx), .top_q(rows_q[0]), .bot_q(rows_q[1]),
    .byte_o(out_byte), .rs_o(out_rs)
  );
endmodule

// File: rtl/lcdseq_chk.sv
module lcdseq_chk #(
  parameter int N_ENTRIES = 39
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_byte,
  input logic       out_rs,
  input logic       finished
);
  logic [7:0] seen;
  always_ff @(posedge clk) begin
    if (!rst_n)                    seen <= '0;
    else if (start && !out_valid)  seen <= '0;
    else if (out_valid && out_ready) seen <= seen + 1'b1;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !out_valid && !finished); // R1
  AST_START_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    start && !out_valid |=> out_valid); // R2
  AST_FIRST_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_byte == 8'h02 && !out_rs); // R3
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_byte) && $stable(out_rs)); // R7
  AST_XFER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    seen <= 8'(N_ENTRIES)); // R8
  AST_DONE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(finished) |-> seen == 8'(N_ENTRIES)); // R8
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    finished |-> !out_valid); // R9
  AST_DONE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    finished && !start |=> finished); // R9
endmodule

bind lcd_line_sequencer lcdseq_chk #(.N_ENTRIES(N_ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .out_valid(out_valid),
  .out_ready(out_ready), .out_byte(out_byte), .out_rs(out_rs), .finished(finished)
);

// File: tb/sim_lcd_line_sequencer.sv
module sim_lcd_line_sequencer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic out_ready = 1'b0;
  logic [127:0] row_top = '0, row_bottom = '0;
  logic out_valid, out_rs, finished;
  logic [7:0] out_byte;

  always #2 clk = ~clk;

  lcd_line_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .row_top(row_top),
    .row_bottom(row_bottom), .out_valid(out_valid), .out_ready(out_ready),
    .out_byte(out_byte), .out_rs(out_rs), .finished(finished)
  );

  int total = 0, bad = 0, cycles = 0, accepts = 0;
  logic [8:0] m_q[$];
  bit m_busy = 0, m_done = 0, m_stalled = 0;
  int m_pos = 0;
  logic [8:0] m_prev = '0;

  task automatic chk(input string tag, input bit ok, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic void build(input logic [127:0] a, input logic [127:0] b);
    logic [7:0] init[6] = '{8'h02, 8'h28, 8'h0C, 8'h06, 8'h01, 8'h80};
    m_q = {};
    foreach (init[i]) m_q.push_back({1'b0, init[i]});
    for (int c = 0; c < 16; c++) m_q.push_back({1'b1, a[127 - 8*c -: 8]});
    m_q.push_back({1'b0, 8'hC0});
    for (int c = 0; c < 16; c++) m_q.push_back({1'b1, b[127 - 8*c -: 8]});
  endfunction

  // reference model, same edges as the design
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_pos = 0; m_stalled = 0;
    end else if (m_busy) begin
      m_stalled = !out_ready;
      m_prev = m_q[m_pos];
      if (out_ready) begin
        accepts++;
        if (m_pos == 38) begin m_busy = 0; m_done = 1; end
        else m_pos++;
      end
    end else if (start) begin
      build(row_top, row_bottom);
      m_busy = 1; m_done = 0; m_pos = 0; m_stalled = 0; accepts = 0;
    end
  end

  function automatic string tag_of(input int p);
    if (p == 0) return "R2";
    if (p < 6) return "R3";
    if (p < 22) return "R4";
    if (p == 22) return "R5";
    return "R6";
  endfunction

  // compare every cycle at the falling edge
  always @(negedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
    if (!rst_n || cycles < 2) begin
    end else begin
      string t = m_busy ? "R8" : (m_done ? "R9" : "R1");
      chk(t, out_valid == m_busy, 16'(out_valid), 16'(m_busy));
      chk(t, finished == m_done, 16'(finished), 16'(m_done));
      if (m_busy) begin
        chk(tag_of(m_pos), {out_rs, out_byte} == m_q[m_pos], 16'({out_rs, out_byte}), 16'(m_q[m_pos]));
        if (m_stalled)
          chk("R7", {out_rs, out_byte} == m_prev, 16'({out_rs, out_byte}), 16'(m_prev));
      end
    end
  end

  logic [7:0] lf = 8'hA5;
  int mode = 0;
  always @(negedge clk) begin
    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    case (mode)
      0: out_ready = 1'b1;
      1: out_ready = lf[0];
      default: out_ready = (lf[1:0] == 2'b00);
    endcase
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done;
    int g = 0;
    while (!m_done && g < 2000) begin @(negedge clk); g++; end
  endtask

  int b0;
  initial begin
    tick(3);
    chk("R1", !out_valid && !finished, 16'({out_valid, finished}), 16'h0);
    @(negedge clk); rst_n = 1'b1;
    tick(3);
    chk("R1", !out_valid && !finished, 16'({out_valid, finished}), 16'h0);

    // full run, ready always high
    row_top = "Hello, display! ";
    row_bottom = "0123456789ABCDEF";
    mode = 0;
    pulse_start();
    wait_done();
    chk("R8", accepts == 39, 16'(accepts), 16'd39);
    tick(6);
    chk("R9", finished && !out_valid, 16'({finished, out_valid}), 16'b10);

    // restart with random ready, rows and start poked mid-run
    mode = 1;
    row_top = "second run  top ";
    row_bottom = "second run  bot ";
    pulse_start();
    b0 = bad;
    tick(15);
    row_top = "XXXXXXXXXXXXXXXX";
    row_bottom = "YYYYYYYYYYYYYYYY";
    tick(5);
    pulse_start();
    tick(5);
    wait_done();
    chk("R10", bad == b0, 16'(bad - b0), 16'd0);
    chk("R11", accepts == 39, 16'(accepts), 16'd39);

    // heavy back-pressure
    mode = 2;
    row_top = "stall stall stal";
    row_bottom = "pressure test ok";
    pulse_start();
    wait_done();
    chk("R7", accepts == 39, 16'(accepts), 16'd39);

    // reset mid-run
    mode = 1;
    pulse_start();
    tick(20);
    rst_n = 1'b0;
    tick(2);
    chk("R1", !out_valid && !finished, 16'({out_valid, finished}), 16'h0);
    rst_n = 1'b1;
    tick(4);
    chk("R1", !out_valid && !finished, 16'({out_valid, finished}), 16'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule